// File: doc/BRIEF.md
# Power-On Reset Sequencer with Configuration Strap Capture

This block runs the power-on reset flow of a signal-processing chip from a single input clock. An active-low external power-on reset is filtered so that only a low level held long enough counts as a real reset. A qualified reset puts the whole sequence back to its starting point. Once the external reset is released, the block holds the internal power-on reset for a fixed span. It then waits fixed spans that stand for the PLL and DLL locking. Last, it releases the chip-wide hard reset. Every span is a count of input clock cycles and is set by a parameter, so a testbench can shorten the whole flow.

The configuration straps are captured at two different moments. The configuration-role, host-port, boot-mode and DLL-enable straps are taken on the release of the external reset. The debug strap is taken only when PLL lock is reached. The captured values are decoded into registered outputs. These outputs select the configuration role, the host-port and bus-width settings, the boot source, a reserved-code error, and whether the core enters debug or normal operation after reset.

The external reset input is assumed to be already synchronous to the clock. All outputs come straight from flip-flops.

Top module: `por_seq_top`

## Requirements
- R1: When `ext_por_n` is sampled low on QUAL_CYC consecutive rising edges (default 16), the edge of the last such sample clears everything. After that edge `state_o` is 0, `int_por_n`, `hard_rst_n`, `pll_lock` and `dll_lock` are 0, and every strap-derived output is 0. All of them stay so while the input remains low.
- R2: A low pulse on `ext_por_n` shorter than QUAL_CYC samples has no effect on any output or on the running sequence.
- R3: Call E0 the first edge that samples `ext_por_n` high after a qualified reset. `int_por_n` becomes 1 at edge E0+IPOR_CYC (default 1024).
- R4: `pll_lock` becomes 1 PLL_CYC edges (default 800) after `int_por_n` rises.
- R5: When the DLL-enable strap captured at E0 is 1, `dll_lock` rises DLL_CYC edges (default 3073) after `pll_lock`. When it is 0, `dll_lock` rises on the same edge as `pll_lock`.
- R6: `hard_rst_n` becomes 1 HRST_DLL_CYC edges (default 3585) after `pll_lock` when the DLL is enabled, and HRST_NODLL_CYC edges (default 512) after it when the DLL is disabled.
- R7: At E0, `cfg_slave` takes the value of `strap_cfg`: 0 means configuration master, 1 means configuration slave.
- R8: At E0, `host_en`, `bus32` and `host_cfg_req` all take the value of `strap_host`. A 0 on all three means the hardware configuration path is in use.
- R9: At E0, `boot_sel` takes `strap_boot`: 00 is external-memory boot and 01 is host-interface boot. `boot_err` is 1 exactly when the captured code is 10 or 11.
- R10: `strap_dbg` is sampled on the edge where `pll_lock` rises. On the edge where `hard_rst_n` rises, `dbg_mode` takes the sampled value and `norm_run` takes its inverse. Before that edge both are 0.
- R11: `state_o` encodes the phase: 0 reset held, 1 internal reset wait, 2 PLL wait, 3 DLL wait, 4 hard-reset wait, 5 running. It changes on the same edges as the outputs above.
- R12: After E0, changes on `strap_cfg`, `strap_host`, `strap_boot` and `dll_en` do not change any output. Changes on `strap_dbg` after the PLL-lock edge do not change any output either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single input clock; all spans are counted in it |
| ext_por_n | input | 1 | External power-on reset, active low, synchronous to clk |
| dll_en | input | 1 | DLL-enable strap, captured at reset release |
| strap_cfg | input | 1 | Configuration-role strap |
| strap_host | input | 1 | Host-port-enable strap |
| strap_boot | input | 2 | Boot-mode strap |
| strap_dbg | input | 1 | Debug-entry strap, sampled at PLL lock |
| int_por_n | output | 1 | Internal power-on reset, active low |
| pll_lock | output | 1 | PLL lock indication |
| dll_lock | output | 1 | DLL lock indication |
| hard_rst_n | output | 1 | Hard reset, active low |
| cfg_slave | output | 1 | 1 = configuration slave, 0 = master |
| host_en | output | 1 | Host port enabled |
| bus32 | output | 1 | 32-bit system data bus selected |
| host_cfg_req | output | 1 | Host must supply the configuration word |
| boot_sel | output | 2 | Captured boot code |
| boot_err | output | 1 | Captured boot code is reserved |
| dbg_mode | output | 1 | Core enters debug after reset |
| norm_run | output | 1 | Core starts normal execution after reset |
| state_o | output | 3 | Sequencer phase |

## Verification
A counter or state that is off by one shows up at the ports as a lock flag or reset release that moves by a cycle. A reference model that tracks elapsed cycles since release catches this on the very edge where the flag should change. A strap captured at the wrong moment shows as a decoded output that differs right at the release edge or at the PLL-lock edge. A glitch filter that trips too early drives `state_o` back to 0 within one cycle of the short pulse. Because every output is compared on every cycle, no faulty phase can stay hidden for more than one edge after it should have moved.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_IPOR = 3'd1,
    ST_PLL  = 3'd2,
    ST_DLL  = 3'd3,
    ST_HRST = 3'd4,
    ST_RUN  = 3'd5
  } seq_state_e;

  // Span from PLL lock to hard-reset release, picked by the captured DLL strap.
  function automatic int unsigned hrst_span(input logic dll_on,
                                            input int unsigned with_dll,
                                            input int unsigned without_dll);
    return dll_on ? with_dll : without_dll;
  endfunction

  // A boot code with its upper bit set is reserved.
  function automatic logic boot_reserved(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/por_qual.sv
module por_qual #(
  parameter int unsigned QUAL_CYC = 16
) (
  input  logic clk,
  input  logic ext_por_n,
  output logic qual_rst
);
  localparam int unsigned LW = $clog2(QUAL_CYC + 1);

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (ext_por_n)
      lo_cnt <= '0;
    else if (lo_cnt != LW'(QUAL_CYC))
      lo_cnt <= lo_cnt + 1'b1;
  end

  // Qualified on the QUAL_CYC-th consecutive low sample, held while low.
  assign qual_rst = !ext_por_n && (lo_cnt >= LW'(QUAL_CYC - 1));

  // R2: a reset cannot qualify on the first low sample after a high one
  p_no_instant_qual_r2: assert property (@(posedge clk) disable iff (ext_por_n)
    qual_rst |-> !$past(ext_por_n));

endmodule

// File: rtl/por_strap_cap.sv
module por_strap_cap
  import por_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_i,
  input  logic       capture_i,
  input  logic       strap_cfg,
  input  logic       strap_host,
  input  logic [1:0] strap_boot,
  output logic       cfg_slave_o,
  output logic       host_en_o,
  output logic       bus32_o,
  output logic       host_cfg_req_o,
  output logic [1:0] boot_sel_o,
  output logic       boot_err_o
);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cfg_slave_o    <= 1'b0;
      host_en_o      <= 1'b0;
      bus32_o        <= 1'b0;
      host_cfg_req_o <= 1'b0;
      boot_sel_o     <= 2'b00;
      boot_err_o     <= 1'b0;
    end else if (capture_i) begin
      cfg_slave_o    <= strap_cfg;
      host_en_o      <= strap_host;
      bus32_o        <= strap_host;
      host_cfg_req_o <= strap_host;
      boot_sel_o     <= strap_boot;
      boot_err_o     <= boot_reserved(strap_boot);
    end
  end

  // R12: captured straps hold between capture events
  p_strap_hold_r12: assert property (@(posedge clk) disable iff (rst_i)
    !capture_i |=> $stable(cfg_slave_o) && $stable(boot_sel_o) && $stable(host_en_o));

  // R8: the three host-derived flags always agree
  p_host_flags_r8: assert property (@(posedge clk) disable iff (rst_i)
    capture_i |=> (host_en_o == bus32_o) && (bus32_o == host_cfg_req_o));

  // R9: an error flag only ever appears with a reserved code
  p_boot_err_r9: assert property (@(posedge clk) disable iff (rst_i)
    $rose(boot_err_o) |-> boot_sel_o[1]);

endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int unsigned IPOR_CYC       = 1024,
  parameter int unsigned PLL_CYC        = 800,
  parameter int unsigned DLL_CYC        = 3073,
  parameter int unsigned HRST_DLL_CYC   = 3585,
  parameter int unsigned HRST_NODLL_CYC = 512
) (
  input  logic       clk,
  input  logic       rst_i,
  input  logic       ext_por_n,
  input  logic       dll_en,
  input  logic       strap_dbg,
  output logic       capture_o,
  output logic [2:0] state_o,
  output logic       int_por_n_o,
  output logic       pll_lock_o,
  output logic       dll_lock_o,
  output logic       hard_rst_n_o,
  output logic       dbg_mode_o,
  output logic       norm_run_o
);
  localparam int unsigned MAXC =
    max2(max2(IPOR_CYC, PLL_CYC), max2(max2(DLL_CYC, HRST_DLL_CYC), HRST_NODLL_CYC));
  localparam int unsigned CW = $clog2(MAXC + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          dll_on_q;
  logic          dbg_q;

  // Named internal events.
  logic ipor_done, pll_done, dll_done, hrst_done;
  assign ipor_done = (cnt_q == CW'(IPOR_CYC - 1));
  assign pll_done  = (cnt_q == CW'(PLL_CYC - 1));
  assign dll_done  = (cnt_q == CW'(DLL_CYC - 1));
  assign hrst_done = (cnt_q == CW'(hrst_span(dll_on_q, HRST_DLL_CYC, HRST_NODLL_CYC) - 1));

  assign capture_o = !rst_i && ext_por_n && (state_q == ST_IDLE);
  assign state_o   = state_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      dll_on_q     <= 1'b0;
      dbg_q        <= 1'b0;
      int_por_n_o  <= 1'b0;
      pll_lock_o   <= 1'b0;
      dll_lock_o   <= 1'b0;
      hard_rst_n_o <= 1'b0;
      dbg_mode_o   <= 1'b0;
      norm_run_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ext_por_n) begin
          state_q  <= ST_IPOR;
          cnt_q    <= '0;
          dll_on_q <= dll_en;
        end
        ST_IPOR: if (ipor_done) begin
          int_por_n_o <= 1'b1;
          state_q     <= ST_PLL;
          cnt_q       <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        ST_PLL: if (pll_done) begin
          pll_lock_o <= 1'b1;
          dbg_q      <= strap_dbg;
          cnt_q      <= '0;
          if (dll_on_q) state_q <= ST_DLL;
          else begin
            state_q    <= ST_HRST;
            dll_lock_o <= 1'b1;
          end
        end else cnt_q <= cnt_q + 1'b1;
        ST_DLL: begin
          cnt_q <= cnt_q + 1'b1;
          if (dll_done) begin
            dll_lock_o <= 1'b1;
            state_q    <= ST_HRST;
          end
        end
        ST_HRST: begin
          cnt_q <= cnt_q + 1'b1;
          if (hrst_done) begin
            hard_rst_n_o <= 1'b1;
            dbg_mode_o   <= dbg_q;
            norm_run_o   <= !dbg_q;
            state_q      <= ST_RUN;
          end
        end
        ST_RUN: ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: PLL lock never rises while internal reset is held
  p_pll_after_ipor_r4: assert property (@(posedge clk) disable iff (rst_i)
    $rose(pll_lock_o) |-> int_por_n_o);

  // R5: the DLL wait phase only exists between the two lock flags
  p_dll_phase_r5: assert property (@(posedge clk) disable iff (rst_i)
    (state_q == ST_DLL) |-> pll_lock_o && !dll_lock_o);

  // R6: hard reset released only with both locks present
  p_hrst_locks_r6: assert property (@(posedge clk) disable iff (rst_i)
    hard_rst_n_o |-> pll_lock_o && dll_lock_o);

  // R10: debug and normal entry are exclusive and follow hard-reset release
  p_mode_excl_r10: assert property (@(posedge clk) disable iff (rst_i)
    (dbg_mode_o || norm_run_o) |-> hard_rst_n_o && !(dbg_mode_o && norm_run_o));

  // R11: running phase once hard reset is released
  p_run_state_r11: assert property (@(posedge clk) disable iff (rst_i)
    $rose(hard_rst_n_o) |-> state_q == ST_RUN);

endmodule

// File: rtl/por_seq_top.sv
module por_seq_top
  import por_seq_pkg::*;
#(
  parameter int unsigned QUAL_CYC       = 16,
  parameter int unsigned IPOR_CYC       = 1024,
  parameter int unsigned PLL_CYC        = 800,
  parameter int unsigned DLL_CYC        = 3073,
  parameter int unsigned HRST_DLL_CYC   = 3585,
  parameter int unsigned HRST_NODLL_CYC = 512
) (
  input  logic       clk,
  input  logic       ext_por_n,
  input  logic       dll_en,
  input  logic       strap_cfg,
  input  logic       strap_host,
  input  logic [1:0] strap_boot,
  input  logic       strap_dbg,
  output logic       int_por_n,
  output logic       pll_lock,
  output logic       dll_lock,
  output logic       hard_rst_n,
  output logic       cfg_slave,
  output logic       host_en,
  output logic       bus32,
  output logic       host_cfg_req,
  output logic [1:0] boot_sel,
  output logic       boot_err,
  output logic       dbg_mode,
  output logic       norm_run,
  output logic [2:0] state_o
);

  logic qual_rst;
  logic capture;

  por_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk       (clk),
    .ext_por_n (ext_por_n),
    .qual_rst  (qual_rst)
  );

  por_seq_fsm #(
    .IPOR_CYC       (IPOR_CYC),
    .PLL_CYC        (PLL_CYC),
    .DLL_CYC        (DLL_CYC),
    .HRST_DLL_CYC   (HRST_DLL_CYC),
    .HRST_NODLL_CYC (HRST_NODLL_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst_i        (qual_rst),
    .ext_por_n    (ext_por_n),
    .dll_en       (dll_en),
    .strap_dbg    (strap_dbg),
    .capture_o    (capture),
    .state_o      (state_o),
    .int_por_n_o  (int_por_n),
    .pll_lock_o   (pll_lock),
    .dll_lock_o   (dll_lock),
    .hard_rst_n_o (hard_rst_n),
    .dbg_mode_o   (dbg_mode),
    .norm_run_o   (norm_run)
  );

  por_strap_cap u_strap (
    .clk            (clk),
    .rst_i          (qual_rst),
    .capture_i      (capture),
    .strap_cfg      (strap_cfg),
    .strap_host     (strap_host),
    .strap_boot     (strap_boot),
    .cfg_slave_o    (cfg_slave),
    .host_en_o      (host_en),
    .bus32_o        (bus32),
    .host_cfg_req_o (host_cfg_req),
    .boot_sel_o     (boot_sel),
    .boot_err_o     (boot_err)
  );

  // R1: a qualified reset leaves everything cleared on the next edge
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (ext_por_n)
    qual_rst |=> (state_o == 3'd0) && !int_por_n && !hard_rst_n && !pll_lock
                 && !dll_lock && !cfg_slave && !host_en && !boot_err);

  // R3: internal reset released only after leaving the idle phase
  p_ipor_release_r3: assert property (@(posedge clk) disable iff (qual_rst)
    $rose(int_por_n) |-> $past(state_o) == 3'd1);

endmodule

// File: tb/por_seq_top_tb_top.sv
module por_seq_top_tb_top;
  localparam int G  = 16;
  localparam int I  = 40;
  localparam int P  = 30;
  localparam int D  = 50;
  localparam int HD = 70;
  localparam int HN = 20;

  logic clk = 1'b0;
  logic ext_por_n = 1'b1, dll_en = 1'b0, strap_cfg = 1'b0, strap_host = 1'b0, strap_dbg = 1'b0;
  logic [1:0] strap_boot = 2'b00;
  logic int_por_n, pll_lock, dll_lock, hard_rst_n, cfg_slave, host_en, bus32, host_cfg_req;
  logic [1:0] boot_sel;
  logic boot_err, dbg_mode, norm_run;
  logic [2:0] state_o;

  always #10 clk = ~clk;

  por_seq_top #(.QUAL_CYC(G), .IPOR_CYC(I), .PLL_CYC(P), .DLL_CYC(D),
                .HRST_DLL_CYC(HD), .HRST_NODLL_CYC(HN)) dut_i (
    .clk(clk), .ext_por_n(ext_por_n), .dll_en(dll_en), .strap_cfg(strap_cfg),
    .strap_host(strap_host), .strap_boot(strap_boot), .strap_dbg(strap_dbg),
    .int_por_n(int_por_n), .pll_lock(pll_lock), .dll_lock(dll_lock),
    .hard_rst_n(hard_rst_n), .cfg_slave(cfg_slave), .host_en(host_en), .bus32(bus32),
    .host_cfg_req(host_cfg_req), .boot_sel(boot_sel), .boot_err(boot_err),
    .dbg_mode(dbg_mode), .norm_run(norm_run), .state_o(state_o));

  int n_chk = 0, n_bad = 0, cyc = 0;

  // Reference model: elapsed cycles since release, plus captured values.
  int lo = 0, t = 0;
  bit synced = 0, active = 0;
  bit m_cfg = 0, m_host = 0, m_dll = 0, m_dbg = 0;
  int m_boot = 0;

  always @(posedge clk) begin
    cyc++;
    if (!ext_por_n) lo++; else lo = 0;
    if (!ext_por_n && lo >= G) begin
      synced = 1; active = 0; t = 0;
      m_cfg = 0; m_host = 0; m_dll = 0; m_dbg = 0; m_boot = 0;
    end else if (synced && !active && ext_por_n) begin
      active = 1; t = 0;
      m_cfg = strap_cfg; m_host = strap_host; m_boot = int'(strap_boot); m_dll = dll_en;
    end else if (active) begin
      if (t < 100000) t++;
      if (t == I + P) m_dbg = strap_dbg;
    end
  end

  function automatic int hspan();
    return m_dll ? HD : HN;
  endfunction

  function automatic int exp_state();
    if (!active) return 0;
    if (t < I) return 1;
    if (t < I + P) return 2;
    if (m_dll && t < I + P + D) return 3;
    if (t < I + P + hspan()) return 4;
    return 5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (synced) begin
      chk("R11 state", int'(state_o), exp_state());
      chk("R3 int_por_n", int'(int_por_n), int'(active && t >= I));
      chk("R4 pll_lock", int'(pll_lock), int'(active && t >= I + P));
      chk("R5 dll_lock", int'(dll_lock), int'(active && t >= I + P + (m_dll ? D : 0)));
      chk("R6 hard_rst_n", int'(hard_rst_n), int'(active && t >= I + P + hspan()));
      chk("R7 cfg_slave", int'(cfg_slave), int'(m_cfg));
      chk("R8 host flags", int'({host_en, bus32, host_cfg_req}), m_host ? 7 : 0);
      chk("R9 boot_sel", int'(boot_sel), m_boot);
      chk("R9 boot_err", int'(boot_err), int'(m_boot >= 2));
      chk("R10 dbg_mode", int'(dbg_mode), int'(active && t >= I + P + hspan() && m_dbg));
      chk("R10 norm_run", int'(norm_run), int'(active && t >= I + P + hspan() && !m_dbg));
    end
  end

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #2;
  endtask

  task automatic set_straps(input bit c, input bit h, input bit [1:0] b, input bit dl, input bit dg);
    strap_cfg = c; strap_host = h; strap_boot = b; dll_en = dl; strap_dbg = dg;
  endtask

  initial begin
    #2;
    wait_cyc(3);
    ext_por_n = 0; wait_cyc(20);
    chk("R1 state after qualified reset", int'(state_o), 0);
    chk("R1 hard_rst_n held", int'(hard_rst_n), 0);

    // DLL on, slave, host on, host boot, debug strap later lowered
    set_straps(1, 1, 2'b01, 1, 1);
    ext_por_n = 1; wait_cyc(10);
    set_straps(0, 0, 2'b11, 0, 0);
    wait_cyc(5);
    chk("R12 cfg_slave after strap change", int'(cfg_slave), 1);
    chk("R12 boot_sel after strap change", int'(boot_sel), 1);
    ext_por_n = 0; wait_cyc(15); ext_por_n = 1;   // R2: 15-sample pulse
    wait_cyc(1);
    chk("R2 state after short pulse", int'(state_o), 1);
    chk("R2 int_por_n after short pulse", int'(int_por_n), 0);
    wait_cyc(200);
    chk("R11 running", int'(state_o), 5);
    strap_dbg = 1; wait_cyc(3);
    chk("R12 dbg strap after lock", int'(norm_run), 1);

    // exactly G low samples: qualified
    ext_por_n = 0; wait_cyc(G);
    chk("R1 state after exact-length reset", int'(state_o), 0);
    chk("R1 straps cleared", int'(cfg_slave), 0);
    set_straps(0, 0, 2'b10, 0, 1);
    wait_cyc(2);
    ext_por_n = 1; wait_cyc(120);
    chk("R9 reserved boot flagged", int'(boot_err), 1);
    chk("R10 debug entry", int'(dbg_mode), 1);

    // reset in the middle of the PLL wait
    ext_por_n = 0; wait_cyc(20);
    set_straps(1, 0, 2'b11, 1, 1);
    ext_por_n = 1; wait_cyc(50);
    chk("R11 in PLL wait", int'(state_o), 2);
    ext_por_n = 0; wait_cyc(18);
    chk("R1 reset from PLL wait", int'(pll_lock), 0);
    set_straps(0, 1, 2'b00, 1, 0);
    ext_por_n = 1; wait_cyc(200);
    chk("R8 host enabled", int'(host_cfg_req), 1);
    chk("R6 hard reset released", int'(hard_rst_n), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule